// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter

This block sits behind a 9-bit UART receiver in a slave node on a shared RS-485 bus. Each received character arrives as an 8-bit value, a ninth flag bit and a valid strobe, along with a flag that reports a framing error. When the ninth bit is set, the character is an address. When it is clear, the character is data. The filter decides, one character at a time, whether to hand the character to the receive FIFO interface or to drop it. Either way it leaves the UART framing and the FIFO to the blocks around it.

The filter has two modes. In automatic mode, an internal enable flag tracks whether the last address seen was this node's address, and data characters pass only while that flag is set. In manual mode, every address character is passed on and signalled. Software then decides whether the data that follows is wanted, using a receive-disable input. Every output is registered, so a character accepted in cycle N shows up at the outputs in cycle N+1.

Top module: `rs485_addr_filter`

## Requirements
- R1: A character with `in_bit9`=1 is an address character and one with `in_bit9`=0 is a data character; every forwarded character carries this class on `out_is_addr` (1 = address).
- R2: During reset and after it, `out_valid` and `addr_det` are 0. The automatic receive enable starts cleared, so data characters are dropped in automatic mode until a matching address arrives.
- R3: In automatic mode, an error-free address character equal to `slave_addr` is forwarded in the next cycle with `out_is_addr`=1. `addr_det` is high for that one cycle, and the receive enable is set.
- R4: In automatic mode, an error-free address character not equal to `slave_addr` is not forwarded and does not raise `addr_det`. It clears the receive enable, and data characters are then dropped until the next address character.
- R5: In automatic mode with the enable set, an error-free data character is forwarded in the next cycle with its 8 bits unchanged and `out_is_addr`=0.
- R6: In manual mode, every error-free address character is forwarded with `addr_det` high, whatever its value. A data character is forwarded if and only if `rx_disable` is 0 in the cycle it arrives.
- R7: A character with `in_frame_err`=1 is never forwarded, never raises `addr_det`, and leaves the automatic receive enable unchanged.
- R8: Characters received in manual mode do not change the automatic receive enable. On return to automatic mode, the enable is the one that was in force before.
- R9: A cycle with `in_valid`=0 leaves `out_valid` and `addr_det` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_auto | input | 1 | 1 = automatic filtering, 0 = manual filtering |
| slave_addr | input | 8 | This node's address |
| rx_disable | input | 1 | Manual mode: 1 drops data characters |
| in_valid | input | 1 | Character strobe from the UART receiver |
| in_data | input | 8 | Received 8-bit value |
| in_bit9 | input | 1 | Ninth bit: 1 = address, 0 = data |
| in_frame_err | input | 1 | Character failed the framing check |
| out_valid | output | 1 | Forwarded character strobe |
| out_data | output | 8 | Forwarded 8-bit value |
| out_is_addr | output | 1 | Forwarded character is an address |
| addr_det | output | 1 | One-cycle address-detected pulse |

## Verification
The assertions assume three things about the inputs. `in_bit9`, `in_data` and `in_frame_err` are meaningful only while `in_valid` is high. `mode_auto` and `slave_addr` are sampled in the same cycle as the character they apply to. The internal reset has been released. The random stimulus draws the data and flag values on every cycle, including idle ones, so that stray values cannot leak through. It also biases the address characters towards the programmed address, so that matches are frequent. Mode, `rx_disable` and `slave_addr` change only between characters. Directed sequences cover reset, a foreign address followed by data, a frame error while the node is enabled, and a trip through manual mode and back.

// File: rtl/rs485_filt_pkg.sv
package rs485_filt_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              is_addr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [1:0] {
    ACT_DROP      = 2'd0,
    ACT_PASS_DATA = 2'd1,
    ACT_PASS_ADDR = 2'd2
  } fwd_act_e;
endpackage

// File: rtl/afl_rst_sync.sv
module afl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/afl_classify.sv
module afl_classify
  import rs485_filt_pkg::*;
(
  input  logic              in_valid,
  input  logic              in_frame_err,
  input  logic              in_bit9,
  input  logic [CHAR_W-1:0] in_data,
  input  logic [CHAR_W-1:0] slave_addr,
  output logic              good_addr,
  output logic              good_data,
  output logic              addr_hit
);
  logic good;

  always_comb begin
    good      = in_valid && !in_frame_err;
    good_addr = good && in_bit9;
    good_data = good && !in_bit9;
    addr_hit  = (in_data == slave_addr);
  end
endmodule

// File: rtl/afl_gate_state.sv
module afl_gate_state (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_auto,
  input  logic good_addr,
  input  logic addr_hit,
  output logic rx_en_q
);
  logic rx_en_d;
  logic rx_en_ce;

  always_comb begin
    rx_en_ce = mode_auto && good_addr;
    rx_en_d  = addr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_en_q <= 1'b0;
    else if (rx_en_ce) rx_en_q <= rx_en_d;
  end

  p_hold_unless_auto_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_auto && good_addr) |=> $stable(rx_en_q));
  p_match_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_auto && good_addr && addr_hit) |=> rx_en_q);
  p_foreign_disables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_auto && good_addr && !addr_hit) |=> !rx_en_q);
endmodule

// File: rtl/afl_out_stage.sv
module afl_out_stage
  import rs485_filt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fwd_act_e act,
  input  logic     det,
  input  rx_char_t chr,
  output logic     out_valid,
  output rx_char_t out_chr,
  output logic     addr_det
);
  logic     valid_d;
  rx_char_t chr_d;

  always_comb begin
    valid_d = (act != ACT_DROP);
    chr_d   = chr;
    chr_d.is_addr = (act == ACT_PASS_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr_det  <= 1'b0;
      out_chr   <= '0;
    end else begin
      out_valid <= valid_d;
      addr_det  <= det;
      if (valid_d) out_chr <= chr_d;
    end
  end

  p_det_implies_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_det |-> (out_valid && out_chr.is_addr));
endmodule

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter
  import rs485_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_auto,
  input  logic [CHAR_W-1:0] slave_addr,
  input  logic              rx_disable,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              in_frame_err,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_is_addr,
  output logic              addr_det
);
  logic     rst_ni;
  logic     good_addr, good_data, addr_hit;
  logic     rx_en_q;
  logic     det;
  fwd_act_e act;
  rx_char_t chr_in, chr_out;

  afl_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  afl_classify u_cls (
    .in_valid(in_valid), .in_frame_err(in_frame_err), .in_bit9(in_bit9),
    .in_data(in_data), .slave_addr(slave_addr),
    .good_addr(good_addr), .good_data(good_data), .addr_hit(addr_hit));

  afl_gate_state u_gate (
    .clk(clk), .rst_n(rst_ni), .mode_auto(mode_auto),
    .good_addr(good_addr), .addr_hit(addr_hit), .rx_en_q(rx_en_q));

  always_comb begin
    act = ACT_DROP;
    det = 1'b0;
    if (good_addr) begin
      if (!mode_auto || addr_hit) begin
        act = ACT_PASS_ADDR;
        det = 1'b1;
      end
    end else if (good_data) begin
      if (mode_auto ? rx_en_q : !rx_disable) act = ACT_PASS_DATA;
    end
    chr_in.is_addr = in_bit9;
    chr_in.data    = in_data;
  end

  afl_out_stage u_out (
    .clk(clk), .rst_n(rst_ni), .act(act), .det(det), .chr(chr_in),
    .out_valid(out_valid), .out_chr(chr_out), .addr_det(addr_det));

  assign out_data    = chr_out.data;
  assign out_is_addr = chr_out.is_addr;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> (!out_valid && !addr_det));
  p_frame_drop_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_frame_err) |=> (!out_valid && !addr_det));
  p_foreign_drop_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && !in_frame_err && in_bit9 && mode_auto && in_data != slave_addr)
      |=> !out_valid);
  p_data_intact_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && !in_frame_err && !in_bit9) |=>
      (!out_valid || (out_data == $past(in_data) && !out_is_addr)));
  p_class_kept_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && !in_frame_err && in_bit9) |=> (!out_valid || out_is_addr));
endmodule

// File: tb/tb_rs485_addr_filter.sv
module tb_rs485_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_auto, rx_disable, in_valid, in_bit9, in_frame_err;
  logic [7:0] slave_addr, in_data;
  logic       out_valid, out_is_addr, addr_det;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  bit m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .mode_auto(mode_auto), .slave_addr(slave_addr),
    .rx_disable(rx_disable), .in_valid(in_valid), .in_data(in_data),
    .in_bit9(in_bit9), .in_frame_err(in_frame_err), .out_valid(out_valid),
    .out_data(out_data), .out_is_addr(out_is_addr), .addr_det(addr_det));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(bit v, bit fe, bit b9, bit ma, bit hit);
    if (!v)  return "R9";
    if (fe)  return "R7";
    if (!ma) return "R6";
    if (b9)  return hit ? "R3" : "R4";
    return "R5";
  endfunction

  // one character (or idle cycle): drive after negedge, check at next negedge
  task automatic step(input bit v, input bit [7:0] d, input bit b9, input bit fe);
    bit    e_v, e_det, hit;
    string r;
    in_valid = v; in_data = d; in_bit9 = b9; in_frame_err = fe;
    hit = (d == slave_addr);
    e_v = 0; e_det = 0;
    if (v && !fe) begin
      if (b9) begin
        if (!mode_auto || hit) begin e_v = 1; e_det = 1; end
        if (mode_auto) m_en = hit;
      end else begin
        e_v = mode_auto ? m_en : !rx_disable;
      end
    end
    r = req_of(v, fe, b9, mode_auto, hit);
    @(negedge clk);
    chk(r, "out_valid", out_valid, e_v);
    chk(r, "addr_det", addr_det, e_det);
    if (e_v) begin
      chk(r, "out_data", out_data, d);
      chk("R1", "out_is_addr", out_is_addr, b9);
    end
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [7:0] d;
    bit       b9, fe, v;
    void'($urandom(32'h5eed_1485));
    rst_n = 0; mode_auto = 1; rx_disable = 0; slave_addr = 8'h00;
    in_valid = 0; in_data = 8'h00; in_bit9 = 0; in_frame_err = 0; m_en = 0;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid in reset", out_valid, 0);
    chk("R2", "addr_det in reset", addr_det, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid after reset", out_valid, 0);
    // R2: data dropped before any address seen
    step(1, 8'h55, 0, 0);
    // R3: address 0x00 matches reset-valued slave address
    step(1, 8'h00, 1, 0);
    step(1, 8'hA5, 0, 0);
    // R7: frame error while enabled, state kept
    step(1, 8'h00, 1, 1);
    step(1, 8'h3C, 0, 1);
    step(1, 8'h3D, 0, 0);
    // R4: foreign address then data dropped
    slave_addr = 8'h42;
    step(1, 8'h41, 1, 0);
    step(1, 8'h11, 0, 0);
    step(0, 8'hFF, 1, 0);
    step(1, 8'h42, 1, 0);
    // R8: manual trip keeps enable
    mode_auto = 0;
    step(1, 8'h99, 1, 0);
    rx_disable = 1;
    step(1, 8'h12, 0, 0);
    rx_disable = 0;
    step(1, 8'h13, 0, 0);
    mode_auto = 1;
    step(1, 8'h14, 0, 0);
    chk("R8", "enable kept after manual", out_valid, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) mode_auto = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 19) == 0) rx_disable = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) slave_addr = 8'($urandom);
      v  = $urandom_range(0, 3) != 0;
      b9 = $urandom_range(0, 3) == 0;
      fe = $urandom_range(0, 15) == 0;
      d  = (b9 && $urandom_range(0, 1)) ? slave_addr : 8'($urandom);
      step(v, d, b9, fe);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule